// File: doc/BRIEF.md
# Timekeeping Counters with Alarms

This block keeps three free-running binary counters, each paired with an alarm register. The first is a 40-bit real-time clock. The second is a 40-bit interval timer. Both advance on a 256 Hz tick enable, so their low byte holds fractions of a second. The third is a 32-bit cycle counter. It counts high-to-low events on a monitored line, and only those events whose high and low phases each lasted for a selectable settling delay.

The interval timer runs in one of two modes. In manual mode a stop bit in the control register gates it. In automatic mode the qualified level of the monitored line gates it. The settling delay is counted in ticks of a millisecond-scale time base. It has two lengths, chosen by a control bit, and both lengths are parameters.

Alarm flags sit in a status register, and reading that register clears them. An interrupt request is raised for any flag whose enable bit is 0. Counter reads return a snapshot that is captured on a strobe, so a multi-byte value stays consistent while it is read. Write protection is supplied from outside as a three-bit input.

Top module: `tk_timekeeper`

## Requirements
- R1: After reset, all counters, alarms, holding registers, the control byte, the status enables and the flags are 0, `irq` is 0 and `flags` is 0.
- R2: The status byte at address 0x00 reads as bit 0 clock flag, bit 1 interval flag, bit 2 cycle flag, bits 3/4/5 the matching enables, and bits 7:6 as 0. A write to it changes only bits 5:3, and the flag bits of the written byte are ignored.
- R3: The control byte at address 0x01 holds bit 3 read-only, bit 4 oscillator on, bit 5 automatic mode, bit 6 stop and bit 7 long delay. Bits 2:0 always read back as `wp_in` (clock, interval, cycle), and writes to them are ignored.
- R4: Each `tick_256` pulse increments the clock by 1 while the oscillator bit is 1. When it is 0, no counter changes.
- R5: A counter at all ones wraps to 0 on its next increment.
- R6: In manual mode the interval timer increments on each tick while the stop bit is 0. It holds while the stop bit is 1.
- R7: In automatic mode the stop bit is ignored. The interval timer counts ticks only while the qualified line level is high. The qualified level takes the line's value once the line has been stable for `DLY_SHORT` time-base ticks (long-delay bit 0) or `DLY_LONG` time-base ticks (bit 1).
- R8: The cycle counter increments by 1 when the qualified level falls. A high pulse shorter than the selected delay is not counted.
- R9: A flag is set on the clock edge of the increment that makes its counter equal its alarm, including a wrap to 0. A write that makes them equal sets no flag.
- R10: A status read returns the flags as they were before the read, and all flags are clear afterwards.
- R11: `irq` rises one clock after a flag is set whose enable is 0. It falls one clock after that enable is written to 1.
- R12: Counter bytes are read, least significant first, at 0x02 (clock, 5 bytes), 0x0C (interval, 5 bytes) and 0x16 (cycle, 4 bytes). They return the value captured on the last `snap` pulse. Alarms are read live at 0x07, 0x11 and 0x1A.
- R13: While a `wp_in` bit is 1, writes to the matching counter and alarm are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_256 | input | 1 | 256 Hz count enable, one cycle wide |
| tick_tb | input | 1 | Time-base tick for the settling delay |
| line_in | input | 1 | Monitored line level, already synchronized |
| snap | input | 1 | Capture all counters into holding registers |
| wp_in | input | 3 | Write protect: bit 0 clock, bit 1 interval, bit 2 cycle |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 6 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 6 | Byte read address |
| rd_data | output | 8 | Read data, registered |
| flags | output | 3 | Alarm flags (clock, interval, cycle) |
| irq | output | 1 | Interrupt request, registered |

## Verification
Read data appears on the clock edge that takes the read strobe. Counters and flags change on the edge that takes the tick. `irq` follows the flags one edge later. The qualified line level settles one edge after the delay count reaches its limit. The bench drives every stimulus for one cycle from a falling edge and samples at the next falling edge, so every result is read after the edge that produces it. The `irq` checks add one extra falling edge, so both the early and the due value are seen. Line-gated tests hold the line far longer or far shorter than the delay, so those results do not depend on the exact settling cycle.

// File: rtl/tk_pkg.sv
package tk_pkg;
  parameter int RTC_W = 40;
  parameter int CYC_W = 32;
  parameter int AW    = 6;
  parameter int MAXW  = 40;

  localparam int NB_R = RTC_W / 8;
  localparam int NB_C = CYC_W / 8;

  localparam logic [AW-1:0] A_STAT = 6'h00;
  localparam logic [AW-1:0] A_CTRL = 6'h01;

  // per counter: 0 clock, 1 interval, 2 cycle
  localparam int CWID  [3] = '{RTC_W, RTC_W, CYC_W};
  localparam int NBY   [3] = '{NB_R, NB_R, NB_C};
  localparam int CBASE [3] = '{2, 2 + 2*NB_R, 2 + 4*NB_R};
  localparam int ABASE [3] = '{2 + NB_R, 2 + 3*NB_R, 2 + 4*NB_R + NB_C};

  typedef struct packed {
    logic       dsel;
    logic       stop;
    logic       autom;
    logic       osc;
    logic       ro;
  } tk_ctrl_t;
endpackage

// File: rtl/tk_debounce.sv
module tk_debounce #(
  parameter int DLY_SHORT = 4,
  parameter int DLY_LONG  = 123
) (
  input  logic clk,
  input  logic rst,
  input  logic tb,
  input  logic line,
  input  logic dsel,
  output logic q,
  output logic fall
);
  localparam int MAXD = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int CW   = $clog2(MAXD + 1);

  logic          line_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          upd;

  assign lim  = dsel ? CW'(DLY_LONG) : CW'(DLY_SHORT);
  assign upd  = (line == line_d) && (cnt_q >= lim) && (q != line_d);
  assign fall = upd && !line_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_d <= 1'b0;
      cnt_q  <= '0;
      q      <= 1'b0;
    end else if (line != line_d) begin
      line_d <= line;
      cnt_q  <= '0;
    end else begin
      if (tb && cnt_q < lim) cnt_q <= cnt_q + CW'(1);
      if (upd) q <= line_d;
    end
  end

  // R7: the qualified level only moves after the line was stable long enough
  a_r7_settled: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> $past(cnt_q >= lim));
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         cwr,
  input  logic         awr,
  input  logic [2:0]   bsel,
  input  logic [7:0]   wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] alm,
  output logic         hit
);
  localparam int NB = W / 8;

  logic [W-1:0] cnt_n, alm_n, cnt_p1;

  assign cnt_p1 = cnt + W'(1);
  assign hit    = inc && !cwr && (cnt_p1 == alm);

  always_comb begin
    cnt_n = cnt;
    alm_n = alm;
    if (cwr) begin
      for (int b = 0; b < NB; b++)
        if (bsel == 3'(b)) cnt_n[8*b +: 8] = wdata;
    end else if (inc) begin
      cnt_n = cnt_p1;
    end
    if (awr) begin
      for (int b = 0; b < NB; b++)
        if (bsel == 3'(b)) alm_n[8*b +: 8] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      alm <= '0;
    end else begin
      cnt <= cnt_n;
      alm <= alm_n;
    end
  end

  // R4 / R5: one step per increment, wrapping
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !cwr) |=> cnt == $past(cnt) + W'(1));
  // R4: idle counter holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !cwr) |=> $stable(cnt));
  // R9: a hit leaves the counter on the alarm value
  a_r9_hit: assert property (@(posedge clk) disable iff (rst)
    (hit && !awr) |=> cnt == alm);
endmodule

// File: rtl/tk_timekeeper.sv
module tk_timekeeper
  import tk_pkg::*;
#(
  parameter int DLY_SHORT = 4,
  parameter int DLY_LONG  = 123
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_256,
  input  logic          tick_tb,
  input  logic          line_in,
  input  logic          snap,
  input  logic [2:0]    wp_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [2:0]    flags,
  output logic          irq
);
  tk_ctrl_t   ctrl_q;
  logic [2:0] en_q;
  logic [2:0] flags_q;
  logic       irq_q;
  logic       q_lvl, q_fall;

  logic [MAXW-1:0] cnt_all  [3];
  logic [MAXW-1:0] alm_all  [3];
  logic [MAXW-1:0] hold_all [3];
  logic [2:0]      hit, inc, cwr, awr;
  logic [2:0]      bidx [3];
  logic            stat_rd;
  logic [7:0]      rd_mux;

  assign stat_rd = rd_en && (rd_addr == A_STAT);

  tk_debounce #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_deb (
    .clk(clk), .rst(rst), .tb(tick_tb), .line(line_in),
    .dsel(ctrl_q.dsel), .q(q_lvl), .fall(q_fall)
  );

  assign inc[0] = tick_256 && ctrl_q.osc;
  assign inc[1] = tick_256 && ctrl_q.osc && (ctrl_q.autom ? q_lvl : !ctrl_q.stop);
  assign inc[2] = q_fall && ctrl_q.osc;

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    localparam int W = CWID[g];
    logic [W-1:0]    c, a;
    logic [AW-1:0]   coff, aoff;
    logic            csel, asel;

    assign coff = wr_addr - AW'(CBASE[g]);
    assign aoff = wr_addr - AW'(ABASE[g]);
    assign csel = (wr_addr >= AW'(CBASE[g])) && (wr_addr < AW'(CBASE[g] + NBY[g]));
    assign asel = (wr_addr >= AW'(ABASE[g])) && (wr_addr < AW'(ABASE[g] + NBY[g]));
    assign cwr[g]  = wr_en && csel && !wp_in[g];
    assign awr[g]  = wr_en && asel && !wp_in[g];
    assign bidx[g] = csel ? coff[2:0] : aoff[2:0];

    tk_counter #(.W(W)) u_c (
      .clk(clk), .rst(rst), .inc(inc[g]), .cwr(cwr[g]), .awr(awr[g]),
      .bsel(bidx[g]), .wdata(wr_data), .cnt(c), .alm(a), .hit(hit[g])
    );

    assign cnt_all[g] = MAXW'(c);
    assign alm_all[g] = MAXW'(a);

    always_ff @(posedge clk) begin
      if (rst)       hold_all[g] <= '0;
      else if (snap) hold_all[g] <= cnt_all[g];
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (rd_addr == A_STAT) rd_mux = {2'b00, en_q, flags_q};
    else if (rd_addr == A_CTRL) rd_mux = {ctrl_q, wp_in};
    for (int g = 0; g < 3; g++) begin
      logic [AW-1:0] co, ao;
      co = rd_addr - AW'(CBASE[g]);
      ao = rd_addr - AW'(ABASE[g]);
      if (rd_addr >= AW'(CBASE[g]) && rd_addr < AW'(CBASE[g] + NBY[g]))
        rd_mux = 8'(hold_all[g] >> {co[2:0], 3'b000});
      if (rd_addr >= AW'(ABASE[g]) && rd_addr < AW'(ABASE[g] + NBY[g]))
        rd_mux = 8'(alm_all[g] >> {ao[2:0], 3'b000});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      en_q    <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[7:3];
      if (wr_en && wr_addr == A_STAT) en_q   <= wr_data[5:3];
      flags_q <= (stat_rd ? 3'b000 : flags_q) | hit;
      irq_q   <= |(flags_q & ~en_q);
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  // R4: oscillator off freezes every counter
  a_r4_osc_off: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.osc && !wr_en) |=> ($stable(cnt_all[0]) && $stable(cnt_all[1]) && $stable(cnt_all[2])));
  // R10: a status read with no new hit leaves all flags clear
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && hit == 3'b000) |=> flags_q == 3'b000);
  // R11: interrupt only follows a raised flag
  a_r11_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(flags_q != 3'b000));
  // R2: top status bits read as zero
  a_r2_upper: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> rd_data[7:6] == 2'b00);
endmodule

// File: tb/sim_tk_timekeeper.sv
module sim_tk_timekeeper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_256 = 1'b0, tick_tb = 1'b1, line_in = 1'b0, snap = 1'b0;
  logic [2:0] wp_in = 3'b000;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] flags;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  logic [39:0] e_rtc = '0, e_itv = '0, e_cyc = '0;
  logic [7:0]  b8;
  logic [39:0] v;

  localparam logic [5:0] A_ST = 6'h00, A_CT = 6'h01, A_RTC = 6'h02, A_RTCA = 6'h07,
                         A_ITV = 6'h0C, A_CYC = 6'h16;

  always #2.5 clk = ~clk;

  tk_timekeeper u0 (
    .clk(clk), .rst(rst), .tick_256(tick_256), .tick_tb(tick_tb), .line_in(line_in),
    .snap(snap), .wp_in(wp_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_256 = 1'b1;
      @(negedge clk); tick_256 = 1'b0;
    end
  endtask

  task automatic do_snap();
    @(negedge clk); snap = 1'b1;
    @(negedge clk); snap = 1'b0;
  endtask

  task automatic rd_cnt(input logic [5:0] base, input int nb, output logic [39:0] val);
    logic [7:0] t;
    val = '0;
    do_snap();
    for (int b = 0; b < nb; b++) begin
      rd(base + 6'(b), t);
      val[8*b +: 8] = t;
    end
  endtask

  task automatic hold_line(input logic lv, input int n);
    @(negedge clk); line_in = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 flags", 40'(flags), 0);
    chk("R1 irq", 40'(irq), 0);
    rd(A_ST, b8); chk("R1 status", 40'(b8), 0);
    rd(A_CT, b8); chk("R1 control", 40'(b8), 0);
    rd_cnt(A_RTC, 5, v); chk("R1 clock", v, 0);
  endtask

  task automatic t_count();
    wr(A_CT, 8'h10);
    tick(5); e_rtc += 5; e_itv += 5;
    rd_cnt(A_RTC, 5, v); chk("R4 clock count", v, e_rtc);
    rd_cnt(A_ITV, 5, v); chk("R6 interval manual run", v, e_itv);
    wr(A_CT, 8'h00);
    tick(3);
    rd_cnt(A_RTC, 5, v); chk("R4 oscillator off", v, e_rtc);
  endtask

  task automatic t_ctrl();
    wr(A_CT, 8'hFF);
    rd(A_CT, b8); chk("R3 control readback", 40'(b8), 40'h F8);
    wp_in = 3'b101;
    rd(A_CT, b8); chk("R3 protect bits from input", 40'(b8), 40'h FD);
    wp_in = 3'b000;
    wr(A_CT, 8'h10);
  endtask

  task automatic t_manual();
    wr(A_CT, 8'h50);
    tick(4); e_rtc += 4;
    rd_cnt(A_ITV, 5, v); chk("R6 stop holds interval", v, e_itv);
    rd_cnt(A_RTC, 5, v); chk("R6 clock still runs", v, e_rtc);
    wr(A_CT, 8'h10);
    tick(2); e_rtc += 2; e_itv += 2;
    rd_cnt(A_ITV, 5, v); chk("R6 interval resumes", v, e_itv);
  endtask

  task automatic t_wrap();
    for (int b = 0; b < 5; b++) wr(A_RTC + 6'(b), 8'hFF);
    chk("R9 write sets no flag", 40'(flags), 0);
    tick(1); e_rtc = '0; e_itv += 1;
    chk("R9 wrap hits alarm 0", 40'(flags), 1);
    rd_cnt(A_RTC, 5, v); chk("R5 wrap to zero", v, 0);
    rd(A_ST, b8); chk("R10 status returns flag", 40'(b8), 40'h01);
    chk("R10 flags cleared", 40'(flags), 0);
  endtask

  task automatic t_alarm();
    wr(A_RTCA, 8'h03);
    tick(2);
    chk("R9 no early flag", 40'(flags), 0);
    tick(1); e_rtc = 3; e_itv += 3;
    chk("R9 flag on match", 40'(flags), 1);
    chk("R11 irq not yet", 40'(irq), 0);
    @(negedge clk);
    chk("R11 irq one clock later", 40'(irq), 1);
    wr(A_ST, 8'h08);
    @(negedge clk);
    chk("R11 enable masks irq", 40'(irq), 0);
    chk("R11 flag kept while masked", 40'(flags), 1);
    rd(A_ST, b8); chk("R2 status layout", 40'(b8), 40'h09);
    wr(A_ST, 8'h07);
    chk("R2 flag write ignored", 40'(flags), 0);
    rd(A_ST, b8); chk("R2 enables rewritten", 40'(b8), 0);
    wr(A_RTCA, 8'h07);
    wr(A_RTC, 8'h07);
    chk("R9 equal by write no flag", 40'(flags), 0);
    tick(1); e_rtc = 8; e_itv += 1;
    chk("R9 passing alarm no flag", 40'(flags), 0);
  endtask

  task automatic t_snap();
    do_snap();
    tick(3); e_itv += 3;
    for (int b = 0; b < 5; b++) begin
      rd(A_RTC + 6'(b), b8); v[8*b +: 8] = b8;
    end
    chk("R12 holding value stable", v, e_rtc);
    e_rtc += 3;
    rd_cnt(A_RTC, 5, v); chk("R12 new snapshot", v, e_rtc);
  endtask

  task automatic t_wp();
    wp_in = 3'b001;
    wr(A_RTC, 8'h55);
    rd_cnt(A_RTC, 5, v); chk("R13 protected counter", v, e_rtc);
    wr(A_RTCA, 8'h66);
    rd(A_RTCA, b8); chk("R13 protected alarm", 40'(b8), 40'h07);
    wp_in = 3'b000;
  endtask

  task automatic t_cycle();
    wr(A_CT, 8'h10);
    hold_line(1'b1, 2); hold_line(1'b0, 20);
    rd_cnt(A_CYC, 4, v); chk("R8 short pulse ignored", v, e_cyc);
    hold_line(1'b1, 20); hold_line(1'b0, 20); e_cyc += 1;
    rd_cnt(A_CYC, 4, v); chk("R8 qualified fall counts", v, e_cyc);
    wr(A_CT, 8'h90);
    hold_line(1'b1, 50); hold_line(1'b0, 200);
    rd_cnt(A_CYC, 4, v); chk("R8 long delay ignores 50", v, e_cyc);
    hold_line(1'b1, 200); hold_line(1'b0, 200); e_cyc += 1;
    rd_cnt(A_CYC, 4, v); chk("R8 long delay counts 200", v, e_cyc);
  endtask

  task automatic t_auto();
    wr(A_CT, 8'h70);
    tick(3); e_rtc += 3;
    rd_cnt(A_ITV, 5, v); chk("R7 auto low holds, stop ignored", v, e_itv);
    hold_line(1'b1, 20);
    tick(4); e_rtc += 4; e_itv += 4;
    rd_cnt(A_ITV, 5, v); chk("R7 auto high counts", v, e_itv);
    hold_line(1'b0, 20); e_cyc += 1;
    tick(2); e_rtc += 2;
    rd_cnt(A_ITV, 5, v); chk("R7 auto low stops", v, e_itv);
    rd_cnt(A_CYC, 4, v); chk("R8 auto fall counted", v, e_cyc);
    rd_cnt(A_RTC, 5, v); chk("R4 clock total", v, e_rtc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_ctrl();
    t_manual();
    t_wrap();
    t_alarm();
    t_snap();
    t_wp();
    t_cycle();
    t_auto();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule